// File: doc/BRIEF.md
# Secondary Sample Point Bit Checker

While a CAN FD node transmits its data phase, the bits it drives come back through the local transceiver after a loop delay that can span several data bit times. This block queues every transmitted bit together with the time at which its looped-back copy should be sampled. It then compares the receive line with that queued bit at the secondary sample point. A mismatch is not reported at once. It is held and reported as a one-cycle error pulse at the next regular sample point.

The surrounding bit-timing logic supplies four things: a strobe at each transmitted bit start, the bit value, the phase indicators, and the regular sample-point strobe. A separate delay measurement supplies the secondary sample point position in clock quanta. This block neither measures the position nor generates bit timing. Time is counted in clock cycles, with one cycle equal to one quantum.

Top module: `ssp_bit_checker`

## Requirements
- R1: A bit queued at a bit-start strobe on clock edge k is compared with `rx` at edge k+E, where E is the effective position. An inequality is a detected mismatch.
- R2: A detected mismatch makes `bit_err` high for exactly one cycle, on the cycle after the first `sample_pt` strobe that falls strictly after the detecting edge. A strobe on the same edge as the detection does not report that mismatch.
- R3: All mismatches detected between two consecutive `sample_pt` strobes produce a single pulse.
- R4: While `arb_phase` is high or `data_phase` is low, no bit is queued or compared, and every queued bit is discarded.
- R5: The effective position E equals `ssp_pos`, except that values above 127 become 127 and a value of 0 becomes 1.
- R6: Up to DEPTH queued bits may be outstanding at once. Each is compared in the order it was queued, so the position may exceed the data bit time, provided it stays below 6 bit times and is held constant within a frame.
- R7: A high `init` discards all queued bits and any unreported mismatch, and holds `bit_err` low on the following cycle.
- R8: The end of the data phase does not clear a mismatch that was already detected. That mismatch is still reported at the next `sample_pt` strobe.
- R9: After reset `bit_err` is low and no bits are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quantum clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Controller initialisation; flushes all state |
| bit_start | input | 1 | One-cycle strobe at the start of each transmitted bit |
| tx_bit | input | 1 | Value of the bit that starts with `bit_start` |
| rx | input | 1 | Receive line from the transceiver |
| ssp_pos | input | POS_W | Secondary sample point position in quanta from bit start |
| data_phase | input | 1 | High during the data phase, up to the CRC delimiter sample point |
| arb_phase | input | 1 | High during arbitration |
| sample_pt | input | 1 | Regular sample-point strobe |
| bit_err | output | 1 | One-cycle bit-error pulse after a regular sample point |

## Verification
The assertions check four properties on every cycle:
- the queue never accepts a bit while it is full;
- the queue is empty one cycle after any arbitration, inactive or init cycle;
- every error pulse directly follows a regular sample-point strobe;
- no pulse follows an init cycle.

Other behaviour can only be shown by the bench's scenarios, which run against a cycle model of the requirements:
- the exact edge of each comparison;
- the clamping of the position at both ends;
- the in-order service of overlapping bits when the loop delay spans several bit times;
- the merging of several mismatches into one pulse;
- the deferral of a mismatch that coincides with a strobe;
- the survival of a pending error past the end of the data phase.

// File: rtl/ssp_chk_pkg.sv
package ssp_chk_pkg;
  localparam int MAX_OFF = 127;
  localparam int TS_W    = $clog2(MAX_OFF + 1) + 1;

  typedef struct packed {
    logic            bit_val;
    logic [TS_W-1:0] due;
  } pend_bit_t;
endpackage

// File: rtl/ssp_timebase.sv
module ssp_timebase #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end
endmodule

// File: rtl/ssp_due_calc.sv
module ssp_due_calc
  import ssp_chk_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic [POS_W-1:0] pos,
  input  logic [TS_W-1:0]  now,
  output logic [TS_W-1:0]  due
);
  localparam logic [POS_W-1:0] LIMIT = POS_W'(MAX_OFF);
  logic [TS_W-1:0] eff;

  always_comb begin
    if (pos == '0)       eff = TS_W'(1);
    else if (pos > LIMIT) eff = TS_W'(MAX_OFF);
    else                 eff = TS_W'(pos);
    due = now + eff;
  end
endmodule

// File: rtl/ssp_pend_fifo.sv
module ssp_pend_fifo
  import ssp_chk_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      push,
  input  pend_bit_t din,
  input  logic      pop,
  output pend_bit_t head,
  output logic      empty,
  output logic      full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  pend_bit_t         mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push)
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R6: the environment keeps in-flight bits within the queue depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (push && !flush) |-> (!full || pop))
    else $error("queue overflow");

  // R4/R7: a flush leaves the queue empty on the next cycle
  p_flush_empty_r4: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/ssp_err_report.sv
module ssp_err_report (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic mismatch,
  input  logic sample_pt,
  output logic bit_err
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      pending <= 1'b0;
      bit_err <= 1'b0;
    end else begin
      bit_err <= sample_pt && pending;
      pending <= (pending && !sample_pt) || mismatch;
    end
  end

  // R2: a pulse only ever follows a regular sample-point strobe
  p_err_after_sp_r2: assert property (@(posedge clk) disable iff (rst)
    bit_err |-> $past(sample_pt));

  // R7: an init cycle is never followed by a pulse
  p_init_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    init |=> !bit_err);
endmodule

// File: rtl/ssp_bit_checker.sv
module ssp_bit_checker
  import ssp_chk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             bit_start,
  input  logic             tx_bit,
  input  logic             rx,
  input  logic [POS_W-1:0] ssp_pos,
  input  logic             data_phase,
  input  logic             arb_phase,
  input  logic             sample_pt,
  output logic             bit_err
);
  logic [TS_W-1:0] now;
  logic [TS_W-1:0] due;
  pend_bit_t       head, entry;
  logic            empty, full;
  logic            active, hit, mismatch;

  assign active   = data_phase && !arb_phase && !init;
  assign hit      = active && !empty && (head.due == now);
  assign mismatch = hit && (rx != head.bit_val);
  assign entry    = '{bit_val: tx_bit, due: due};

  ssp_timebase #(.W(TS_W)) u_time (
    .clk (clk),
    .rst (rst),
    .now (now)
  );

  ssp_due_calc #(.POS_W(POS_W)) u_due (
    .pos (ssp_pos),
    .now (now),
    .due (due)
  );

  ssp_pend_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (!active),
    .push  (active && bit_start),
    .din   (entry),
    .pop   (hit),
    .head  (head),
    .empty (empty),
    .full  (full)
  );

  ssp_err_report u_rep (
    .clk       (clk),
    .rst       (rst),
    .init      (init),
    .mismatch  (mismatch),
    .sample_pt (sample_pt),
    .bit_err   (bit_err)
  );

  // R4: nothing remains queued after an arbitration or idle cycle
  p_no_queue_in_arb_r4: assert property (@(posedge clk) disable iff (rst)
    (arb_phase || !data_phase) |=> empty);
endmodule

// File: tb/tb_ssp_bit_checker.sv
module tb_ssp_bit_checker;
  logic clk = 1'b0;
  logic rst;
  logic init, bit_start, tx_bit, rx, data_phase, arb_phase, sample_pt;
  logic [7:0] ssp_pos;
  logic bit_err;

  always #2.5 clk = ~clk;

  ssp_bit_checker dut (
    .clk(clk), .rst(rst), .init(init), .bit_start(bit_start),
    .tx_bit(tx_bit), .rx(rx), .ssp_pos(ssp_pos), .data_phase(data_phase),
    .arb_phase(arb_phase), .sample_pt(sample_pt), .bit_err(bit_err)
  );

  int checks = 0, errors = 0;
  int k = 0;
  int q_due[$];
  bit q_bit[$];
  bit m_pend = 0;
  bit exp_err = 0;
  int pulses = 0;
  string cur_req = "R1";
  bit line_hist [256];
  int cycles = 0;

  function automatic int eff_pos(input int p);
    if (p == 0) return 1;
    if (p > 127) return 127;
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, k);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  // one edge: drive, update model, clock, compare
  task automatic step(input bit bs, input bit tx, input bit rxv, input bit sp);
    bit mism;
    bit_start = bs; tx_bit = tx; rx = rxv; sample_pt = sp;
    line_hist[k % 256] = tx;
    if (init) begin
      q_due.delete(); q_bit.delete(); m_pend = 0; exp_err = 0;
    end else begin
      exp_err = sp && m_pend;
      if (sp) m_pend = 0;
      if (data_phase && !arb_phase) begin
        mism = 0;
        if (q_due.size() > 0 && q_due[0] == k) begin
          mism = (rxv != q_bit[0]);
          void'(q_due.pop_front()); void'(q_bit.pop_front());
        end
        if (mism) m_pend = 1;
        if (bs) begin q_due.push_back(k + eff_pos(ssp_pos)); q_bit.push_back(tx); end
      end else begin
        q_due.delete(); q_bit.delete();
      end
    end
    @(posedge clk);
    @(negedge clk);
    k++;
    if (bit_err) pulses++;
    chk(bit_err == exp_err, cur_req, bit_err, exp_err);
  endtask

  task automatic idle(input int n, input bit rxv);
    for (int i = 0; i < n; i++) step(0, 1, rxv, 0);
  endtask

  // a full frame with looped-back rx, delay dly, random flips
  task automatic frame(input int bt, input int pos, input int nbits, input int dly, input int flip_pct);
    bit cur;
    bit rxv;
    ssp_pos = 8'(pos);
    arb_phase = 1; data_phase = 0;
    for (int c = 0; c < 3 * bt; c++)
      step((c % bt) == 0, 1'($urandom), 1'($urandom), (c % bt) == bt / 2);
    arb_phase = 0; data_phase = 1;
    cur = 1;
    for (int b = 0; b < nbits; b++) begin
      cur = 1'($urandom);
      for (int c = 0; c < bt; c++) begin
        rxv = (k >= dly) ? line_hist[(k - dly) % 256] : 1'b1;
        if (c == 0) line_hist[k % 256] = cur;
        if (c == 0 && dly == 0) rxv = cur;
        if (($urandom % 100) < flip_pct) rxv = !rxv;
        step(c == 0, cur, rxv, c == (bt * 7) / 10);
      end
    end
    data_phase = 0;
    for (int c = 0; c < 2 * bt; c++) step(0, 1, 1, (c % bt) == 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst = 1; init = 0; bit_start = 0; tx_bit = 1; rx = 1;
    ssp_pos = 8'd5; data_phase = 0; arb_phase = 0; sample_pt = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(bit_err == 0, "R9", bit_err, 0);

    // R1/R2: single mismatch, reported after a later strobe
    cur_req = "R1"; data_phase = 1; ssp_pos = 8'd5; pulses = 0;
    step(1, 1, 0, 0); idle(4, 1);
    step(0, 1, 0, 0);            // compare edge: rx 0 vs tx 1
    idle(2, 1);
    cur_req = "R2";
    step(0, 1, 1, 1); idle(2, 1);
    chk(pulses == 1, "R2", pulses, 1);

    // R1: matching bit gives no pulse
    cur_req = "R1"; pulses = 0;
    step(1, 0, 1, 0); idle(4, 1); step(0, 1, 0, 0);
    idle(2, 1); step(0, 1, 1, 1); idle(2, 1);
    chk(pulses == 0, "R1", pulses, 0);

    // R2: strobe on the detecting edge defers to the next strobe
    cur_req = "R2"; pulses = 0;
    step(1, 1, 1, 0); idle(4, 1); step(0, 1, 0, 1);
    idle(2, 1);
    chk(pulses == 0, "R2", pulses, 0);
    step(0, 1, 1, 1); idle(2, 1);
    chk(pulses == 1, "R2", pulses, 1);

    // R3: two mismatches merge into one pulse
    cur_req = "R3"; pulses = 0; ssp_pos = 8'd3;
    step(1, 1, 1, 0); step(1, 0, 1, 0); idle(1, 1);
    step(0, 1, 0, 0); step(0, 1, 1, 0);
    idle(2, 1); step(0, 1, 1, 1); idle(3, 1); step(0, 1, 1, 1); idle(2, 1);
    chk(pulses == 1, "R3", pulses, 1);

    // R4: arbitration phase ignores mismatches and discards queue
    cur_req = "R4"; pulses = 0; ssp_pos = 8'd4;
    step(1, 1, 1, 0); arb_phase = 1;
    for (int i = 0; i < 10; i++) step(i % 2 == 0, 1, 0, i == 8);
    arb_phase = 0; idle(6, 0); step(0, 1, 1, 1); idle(2, 1);
    chk(pulses == 0, "R4", pulses, 0);

    // R5: position above 127 clamps; zero becomes one
    cur_req = "R5"; pulses = 0; ssp_pos = 8'd200;
    step(1, 1, 1, 0); idle(125, 1); step(0, 1, 1, 0); step(0, 1, 0, 0);
    idle(1, 1); step(0, 1, 1, 1); idle(2, 1);
    chk(pulses == 1, "R5", pulses, 1);
    pulses = 0; ssp_pos = 8'd0;
    step(1, 0, 0, 0); step(0, 1, 1, 0); idle(1, 1); step(0, 1, 1, 1); idle(2, 1);
    chk(pulses == 1, "R5", pulses, 1);

    // R7: init drops pending error and queued bits
    cur_req = "R7"; pulses = 0; ssp_pos = 8'd3;
    step(1, 1, 1, 0); step(1, 1, 1, 0); idle(1, 1); step(0, 1, 0, 0);
    init = 1; step(0, 1, 0, 1); init = 0;
    idle(3, 0); step(0, 1, 1, 1); idle(2, 1);
    chk(pulses == 0, "R7", pulses, 0);

    // R8: data phase end keeps a detected mismatch
    cur_req = "R8"; pulses = 0; ssp_pos = 8'd2;
    step(1, 1, 1, 0); idle(1, 1); step(0, 1, 0, 0);
    data_phase = 0; idle(3, 1); step(0, 1, 1, 1); idle(2, 1);
    chk(pulses == 1, "R8", pulses, 1);

    // R6: loop delay spanning several bit times, then random frames
    cur_req = "R6";
    frame(3, 16, 30, 14, 10);
    frame(4, 23, 40, 22, 0);
    cur_req = "R1";
    for (int f = 0; f < 40; f++) begin
      int bt, dly, pos;
      bt  = 2 + int'($urandom % 28);
      dly = int'($urandom % (bt * 5));
      pos = dly + int'($urandom % bt);
      if (pos >= 6 * bt) pos = 6 * bt - 1;
      if (pos > 127) pos = ($urandom % 2) ? 127 : 160;
      if (pos > 127 && 127 >= 6 * bt) pos = 6 * bt - 1;
      frame(bt, pos, 10 + int'($urandom % 20), dly, int'($urandom % 15));
    end
    finish_run();
  end
endmodule